// File: doc/BRIEF.md
# Interrupt translator control register

This block is the 32-bit control and status word of an interrupt translation unit. Software uses it to turn the unit on and off, to set a small unit identifier, and to arm an interrupt that reports messages aimed at unmapped targets. Its enable output gates the translation-write path and the command-queue engine.

Turning the unit off is not instantaneous. Clearing the enable bit raises a request asking the mapping cache to write its contents back to memory. The read-only quiescent flag returns to 1 only after that writeback reports done and no transactions are outstanding. Writes that would be unsafe while the unit is busy are filtered. An enable request made before the unit is quiet is dropped. A change of the unit number made while the unit is enabled or busy is also dropped.

Parameters select the revision and the capabilities. One parameter selects whether the quiescent flag reads 1 after enabling until the translation path acknowledges the enable. A second selects whether the unit-number field and the auxiliary control bit exist. A third selects whether the unmapped-message interrupt exists. Software reads the register through a simple port with one cycle of latency.

Top module: `xlat_ctl_reg`

## Requirements
- R1: The register is decoded only at byte offset 0. A read with `rd_en` returns the register image on `rdata` one cycle later. A read at any other offset returns zero. A write at any other offset changes nothing. Image bits: 31 quiescent, 8 interrupt enable, 7:4 unit number, 1 auxiliary control, 0 enable. All other bits read 0 and ignore writes.
- R2: After reset the image is 0x80000000: quiescent 1, all other fields 0. `flush_req`, `xlat_wr_allow`, `cmdq_run` and `err_irq` are 0.
- R3: A write that clears the enable bit while it is 1 sets `flush_req` from the next cycle. `flush_req` holds until a cycle with `flush_done` high. Quiescent reads 0 while `flush_req` is set.
- R4: While disabled, quiescent reads 1 exactly when `flush_req` is 0 and `outstanding` is zero.
- R5: With `NEW_REV_QUIET`=1, a successful enable leaves quiescent reading 1 until `enable_ack` is sampled high, and 0 after that. With `NEW_REV_QUIET`=0, quiescent reads 0 whenever the unit is enabled.
- R6: `xlat_wr_allow` and `cmdq_run` are 1 exactly while the enable bit is 1.
- R7: `err_irq` equals the interrupt-enable bit ANDed with `unmapped_sts`, in the same cycle.
- R8: A write to the unit-number field is ignored when, before the write, the unit is enabled or quiescent reads 0.
- R9: A write that sets the enable bit while disabled and not quiescent leaves the unit disabled.
- R10: With `HAS_UNIT_FIELDS`=0, bits 7:4 and bit 1 read 0. With `HAS_ERR_IRQ`=0, bit 8 reads 0 and `err_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| xlat_wr_allow | output | 1 | Translation writes accepted |
| cmdq_run | output | 1 | Command-queue processing allowed |
| enable_ack | input | 1 | Translation path reports the enable has taken effect |
| flush_req | output | 1 | Cache writeback request, held until done |
| flush_done | input | 1 | Writeback complete pulse |
| outstanding | input | CNT_W | Count of transactions in flight |
| unmapped_sts | input | 1 | Unmapped-message status |
| err_irq | output | 1 | Unmapped-message interrupt |

## Verification
The assertions assume that `flush_done` only pulses while `flush_req` is high. They also assume that `outstanding` holds its value except when the bench changes it between register accesses. The stimulus follows both assumptions: done and acknowledge pulses last one cycle and are issued only after the matching request or enable, and the transaction count is changed only while the port is idle. Two instances with opposite parameter settings share the same stimulus, so the disable and enable sequences are checked against both quiescent rules.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;
  localparam int REG_W     = 32;
  localparam int BIT_QUIET = 31;
  localparam int BIT_IRQEN = 8;
  localparam int UNIT_LSB  = 4;
  localparam int UNIT_W    = 4;
  localparam int BIT_AUX   = 1;
  localparam int BIT_EN    = 0;

  function automatic logic [REG_W-1:0] pack_image(input logic quiet, input logic irq_en,
                                                  input logic [UNIT_W-1:0] unit,
                                                  input logic aux, input logic en);
    logic [REG_W-1:0] img;
    img = '0;
    img[BIT_QUIET] = quiet;
    img[BIT_IRQEN] = irq_en;
    img[UNIT_LSB +: UNIT_W] = unit;
    img[BIT_AUX] = aux;
    img[BIT_EN] = en;
    return img;
  endfunction

  function automatic logic quiet_calc(input logic en, input logic ack_seen,
                                      input logic flush_pend, input logic idle,
                                      input logic show_pending);
    if (en) return show_pending && !ack_seen;
    return !flush_pend && idle;
  endfunction
endpackage

// File: rtl/xlat_ctl_decode.sv
module xlat_ctl_decode #(
  parameter int ADDR_W = 12,
  parameter int OFFSET = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wr_hit,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(OFFSET);
  logic sel;
  assign sel    = (addr == MATCH);
  assign wr_hit = wr_en && sel;
  assign rd_hit = rd_en && sel;
endmodule

// File: rtl/xlat_ctl_quiesce.sv
module xlat_ctl_quiesce
  import xlat_ctl_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter bit SHOW_PENDING = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             wr_en_bit,
  input  logic             enable_ack,
  input  logic             flush_done,
  input  logic [CNT_W-1:0] outstanding,
  output logic             en_q,
  output logic             flush_q,
  output logic             quiet,
  output logic             ena_evt,
  output logic             dis_evt,
  output logic             ena_blocked
);
  logic ack_q;
  logic idle;

  assign idle        = (outstanding == '0);
  assign quiet       = quiet_calc(en_q, ack_q, flush_q, idle, SHOW_PENDING);
  assign ena_evt     = wr_hit && wr_en_bit && !en_q && quiet;
  assign ena_blocked = wr_hit && wr_en_bit && !en_q && !quiet;
  assign dis_evt     = wr_hit && !wr_en_bit && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      if (ena_evt)      en_q <= 1'b1;
      else if (dis_evt) en_q <= 1'b0;

      if (dis_evt)         flush_q <= 1'b1;
      else if (flush_done) flush_q <= 1'b0;

      if (ena_evt)                 ack_q <= 1'b0;
      else if (en_q && enable_ack) ack_q <= 1'b1;
    end
  end
endmodule

// File: rtl/xlat_ctl_fields.sv
module xlat_ctl_fields
  import xlat_ctl_pkg::*;
#(
  parameter bit HAS_UNIT = 1'b1,
  parameter bit HAS_IRQ  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [REG_W-1:0]  wdata,
  input  logic              unit_wr_ok,
  output logic [UNIT_W-1:0] unit_q,
  output logic              aux_q,
  output logic              irq_en_q
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  generate
    if (HAS_UNIT) begin : g_unit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          unit_q <= '0;
          aux_q  <= 1'b0;
        end else if (wr_hit) begin
          aux_q <= wdata[BIT_AUX];
          if (unit_wr_ok) unit_q <= wdata[UNIT_LSB +: UNIT_W];
        end
      end
    end else begin : g_no_unit
      logic unused_unit;
      assign unused_unit = unit_wr_ok;
      assign unit_q = '0;
      assign aux_q  = 1'b0;
    end

    if (HAS_IRQ) begin : g_irq
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_en_q <= 1'b0;
        else if (wr_hit) irq_en_q <= wdata[BIT_IRQEN];
      end
    end else begin : g_no_irq
      assign irq_en_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/xlat_ctl_reg.sv
module xlat_ctl_reg
  import xlat_ctl_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int CNT_W           = 8,
  parameter bit NEW_REV_QUIET   = 1'b1,
  parameter bit HAS_UNIT_FIELDS = 1'b1,
  parameter bit HAS_ERR_IRQ     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic              xlat_wr_allow,
  output logic              cmdq_run,
  input  logic              enable_ack,
  output logic              flush_req,
  input  logic              flush_done,
  input  logic [CNT_W-1:0]  outstanding,
  input  logic              unmapped_sts,
  output logic              err_irq
);
  logic wr_hit, rd_hit;
  logic en_q, quiet, ena_evt, dis_evt, ena_blocked;
  logic unit_wr_ok, unit_wr_blocked;
  logic [UNIT_W-1:0] unit_q;
  logic aux_q, irq_en_q;
  logic [REG_W-1:0] image;

  xlat_ctl_decode #(.ADDR_W(ADDR_W), .OFFSET(0)) dec_i (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  xlat_ctl_quiesce #(.CNT_W(CNT_W), .SHOW_PENDING(NEW_REV_QUIET)) qsc_i (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_en_bit(wdata[BIT_EN]),
    .enable_ack(enable_ack), .flush_done(flush_done), .outstanding(outstanding),
    .en_q(en_q), .flush_q(flush_req), .quiet(quiet), .ena_evt(ena_evt),
    .dis_evt(dis_evt), .ena_blocked(ena_blocked)
  );

  assign unit_wr_ok      = quiet && !en_q;
  assign unit_wr_blocked = wr_hit && !unit_wr_ok;

  xlat_ctl_fields #(.HAS_UNIT(HAS_UNIT_FIELDS), .HAS_IRQ(HAS_ERR_IRQ)) fld_i (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wdata),
    .unit_wr_ok(unit_wr_ok), .unit_q(unit_q), .aux_q(aux_q), .irq_en_q(irq_en_q)
  );

  assign image         = pack_image(quiet, irq_en_q, unit_q, aux_q, en_q);
  assign xlat_wr_allow = en_q;
  assign cmdq_run      = en_q;
  assign err_irq       = irq_en_q && unmapped_sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_hit ? image : '0;
  end
endmodule

// File: rtl/xlat_ctl_reg_chk.sv
module xlat_ctl_reg_chk #(
  parameter int CNT_W  = 8,
  parameter int UNIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlat_wr_allow,
  input logic              flush_req,
  input logic              flush_done,
  input logic [CNT_W-1:0]  outstanding,
  input logic              quiet,
  input logic              ena_blocked,
  input logic              unit_wr_blocked,
  input logic [UNIT_W-1:0] unit_q,
  input logic              err_irq,
  input logic              unmapped_sts,
  input logic              irq_en_q
);
  // R3
  dis_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xlat_wr_allow) |-> flush_req);
  // R3
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_done) |=> flush_req);
  // R4
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !xlat_wr_allow) |-> (!flush_req && outstanding == '0));
  // R9
  ena_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_blocked |=> !xlat_wr_allow);
  // R8
  unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_wr_blocked |=> $stable(unit_q));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (unmapped_sts && irq_en_q));
endmodule

bind xlat_ctl_reg xlat_ctl_reg_chk #(.CNT_W(CNT_W), .UNIT_W(xlat_ctl_pkg::UNIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .xlat_wr_allow(xlat_wr_allow), .flush_req(flush_req),
  .flush_done(flush_done), .outstanding(outstanding), .quiet(quiet),
  .ena_blocked(ena_blocked), .unit_wr_blocked(unit_wr_blocked), .unit_q(unit_q),
  .err_irq(err_irq), .unmapped_sts(unmapped_sts), .irq_en_q(irq_en_q)
);

// File: tb/xlat_ctl_reg_tb_top.sv
module xlat_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        enable_ack = 1'b0, flush_done = 1'b0, unmapped_sts = 1'b0;
  logic [7:0]  outstanding = '0;
  logic [31:0] rdata_i, rdata_l;
  logic        allow_i, run_i, freq_i, irq_i;
  logic        allow_l, run_l, freq_l, irq_l;
  int          errors = 0, checks = 0;
  logic [31:0] r_i, r_l;

  always #2 clk = ~clk;

  xlat_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata_i), .xlat_wr_allow(allow_i), .cmdq_run(run_i), .enable_ack(enable_ack),
    .flush_req(freq_i), .flush_done(flush_done), .outstanding(outstanding),
    .unmapped_sts(unmapped_sts), .err_irq(irq_i)
  );

  xlat_ctl_reg #(.NEW_REV_QUIET(1'b0), .HAS_UNIT_FIELDS(1'b0), .HAS_ERR_IRQ(1'b0)) dut_l (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata_l), .xlat_wr_allow(allow_l), .cmdq_run(run_l), .enable_ack(enable_ack),
    .flush_req(freq_l), .flush_done(flush_done), .outstanding(outstanding),
    .unmapped_sts(unmapped_sts), .err_irq(irq_l)
  );

  function automatic logic [31:0] img(bit q, bit irq, int unit, bit aux, bit en);
    return (q ? 32'h8000_0000 : 32'h0) + (irq ? 32'd256 : 32'd0)
         + 32'(unit % 16) * 32'd16 + (aux ? 32'd2 : 32'd0) + (en ? 32'd1 : 32'd0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0; addr = '0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; addr = '0;
    r_i = rdata_i; r_l = rdata_l;
  endtask

  task automatic pulse_ack();
    @(negedge clk); enable_ack = 1'b1;
    @(negedge clk); enable_ack = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(12'h000);
    chk("R2 image", r_i, 32'h8000_0000);
    chk("R2 legacy image", r_l, 32'h8000_0000);
    chk("R2 outputs", {28'd0, allow_i, run_i, freq_i, irq_i}, 32'd0);

    // R1 R10 R7: sweep all unit values with reserved bits set
    unmapped_sts = 1'b1;
    for (int u = 0; u < 16; u++) begin
      bit irqb, auxb;
      irqb = (u / 2) % 2 == 1;
      auxb = u % 2 == 1;
      wr(12'h000, 32'h7FFF_FE0C | (32'(u) << 4) | (auxb ? 32'd2 : 32'd0)
                  | (irqb ? 32'd256 : 32'd0));
      chk("R7 err_irq", {31'd0, irq_i}, {31'd0, irqb});
      chk("R10 legacy err_irq", {31'd0, irq_l}, 32'd0);
      rd(12'h000);
      chk("R1 image", r_i, img(1, irqb, u, auxb, 0));
      chk("R10 legacy image", r_l, 32'h8000_0000);
    end
    unmapped_sts = 1'b0;
    @(negedge clk);
    chk("R7 err_irq low", {31'd0, irq_i}, 32'd0);

    // R5 R6: enable with unit 5
    wr(12'h000, 32'h0000_0151);
    chk("R6 outputs on", {30'd0, allow_i, run_i}, 32'd3);
    chk("R6 legacy on", {30'd0, allow_l, run_l}, 32'd3);
    rd(12'h000);
    chk("R5 quiet before ack", r_i, img(1, 1, 5, 0, 1));
    chk("R5 legacy enabled", r_l, img(0, 0, 0, 0, 1));
    pulse_ack();
    rd(12'h000);
    chk("R5 quiet after ack", r_i, img(0, 1, 5, 0, 1));

    // R8: unit change while enabled ignored
    wr(12'h000, 32'h0000_0191);
    rd(12'h000);
    chk("R8 unit held while enabled", r_i, img(0, 1, 5, 0, 1));

    // R3 R4: disable with outstanding traffic
    outstanding = 8'd3;
    wr(12'h000, 32'h0000_0150);
    chk("R3 flush_req set", {30'd0, freq_i, freq_l}, 32'd3);
    chk("R6 outputs off", {30'd0, allow_i, run_i}, 32'd0);
    rd(12'h000);
    chk("R3 quiet low while flushing", r_i, img(0, 1, 5, 0, 0));
    chk("R3 legacy quiet low", r_l, 32'd0);
    pulse_done();
    chk("R3 flush_req cleared", {30'd0, freq_i, freq_l}, 32'd0);
    rd(12'h000);
    chk("R4 busy keeps quiet low", r_i, img(0, 1, 5, 0, 0));

    // R9 R8: enable and unit write while not quiet
    wr(12'h000, 32'h0000_0171);
    chk("R9 enable blocked", {30'd0, allow_i, allow_l}, 32'd0);
    rd(12'h000);
    chk("R9 R8 image", r_i, img(0, 1, 5, 0, 0));
    outstanding = 8'd0;
    rd(12'h000);
    chk("R4 quiet after drain", r_i, img(1, 1, 5, 0, 0));
    chk("R4 legacy quiet", r_l, 32'h8000_0000);
    wr(12'h000, 32'h0000_0170);
    rd(12'h000);
    chk("R8 unit write when quiet", r_i, img(1, 1, 7, 0, 0));

    // R3: disable with no traffic waits for flush_done
    wr(12'h000, 32'h0000_0171);
    pulse_ack();
    wr(12'h000, 32'h0000_0170);
    rd(12'h000);
    chk("R3 quiet waits for done", r_i, img(0, 1, 7, 0, 0));
    chk("R3 flush_req held", {31'd0, freq_i}, 32'd1);
    pulse_done();
    rd(12'h000);
    chk("R3 quiet after done", r_i, img(1, 1, 7, 0, 0));

    // R1: other offsets
    wr(12'h004, 32'h0000_0001);
    chk("R1 stray write no enable", {31'd0, allow_i}, 32'd0);
    rd(12'h000);
    chk("R1 image unchanged", r_i, img(1, 1, 7, 0, 0));
    rd(12'h004);
    chk("R1 other offset reads zero", r_i, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule